// File: doc/BRIEF.md
# Delayed LMS Adaptive FIR Filter

This block is a fixed-point transversal adaptive filter. Each accepted sample advances a tap delay line by one. The block forms the filter output as the dot product of the current weights with the newest input vector, and it forms the error as the desired response minus that output. It then adapts every weight. The adaptation uses an error and an input vector that are both `ADAPT_DLY` samples old. A delay of zero gives plain least-mean-squares adaptation. Larger delays let a pipelined implementation be retimed around the update loop.

The step size is a power of two. The error is shifted right arithmetically by `MU_SHIFT` before it scales the regressor. Weights are Q1.(`WFRAC`) fractions, so one unit of weight is 2^WFRAC. The default configuration has 64 taps.

With `LINE_ENH` set, the block works as a line enhancer. The sample input is the desired response. The filter sees that same input after `DECOR_DLY` samples of decorrelation delay, and `d_in` is ignored.

Top module: `dlms_filter`

## Requirements
- R1: A synchronous reset clears the weights, the delay lines and the error history, and drives `out_valid`, `y_out` and `err_out` to zero. The first sample after reset therefore gives `y_out` = 0 and `err_out` equal to its desired response.
- R2: `out_valid` is `in_valid` delayed by exactly one clock. The results for a sample appear in the cycle after it is accepted.
- R3: `y_out` = sat16(floor(sum over k of w_k * u(n-k) / 2^WFRAC)). It uses the weights held before this sample's update, and u(n) is the current filter input.
- R4: `err_out` = sat16(desired - `y_out`), computed from the saturated output.
- R5: After sample n, each weight becomes w_k + floor(floor(e(n-D)/2^MU_SHIFT) * u(n-D-k) / 2^WFRAC), where D = `ADAPT_DLY`. The error history and the delay lines start at zero.
- R6: With `ADAPT_DLY` = 0, the update in R5 uses the error of the same sample. This is standard LMS.
- R7: Every weight saturates to the signed 16-bit range on update. It does not wrap.
- R8: With `LINE_ENH` = 1, the desired response is `x_in` and the filter input is `x_in` from `DECOR_DLY` accepted samples earlier. `d_in` has no effect.
- R9: A cycle with `in_valid` low changes no weight, no delay line and no output register, whatever values `x_in` and `d_in` carry.
- R10: A reset asserted in the middle of operation returns the block to the state of R1. The next samples match a freshly started filter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept `x_in`/`d_in` this cycle |
| x_in | input | 16 | Input sample, two's complement |
| d_in | input | 16 | Desired response (ignored in line-enhancer mode) |
| out_valid | output | 1 | `y_out`/`err_out` hold a new result |
| y_out | output | 16 | Filter output, saturated |
| err_out | output | 16 | Error, desired minus output, saturated |

## Verification
The bench drives a delayed-update instance, a zero-delay instance and a line-enhancer instance from the same stimulus, and compares each against its own integer model. If the error taken for the update were off by one sample, results would drift apart in the sample that follows the delay window. If the regressor were taken from the wrong taps, every later output would go wrong. Idle cycles carry nonzero garbage: a design that sampled data without `in_valid` would misalign every later output. A run of full-scale samples drives the weights into saturation, where wrap-around would flip the output sign. A mid-run reset checks that no history survives.

// File: rtl/dlms_pkg.sv
`timescale 1ns/1ps
package dlms_pkg;
  localparam int DATA_W  = 16;
  localparam int GUARD_W = 8;
  localparam int ACC_W   = 2 * DATA_W + GUARD_W;

  typedef logic signed [DATA_W-1:0] smp_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  localparam acc_t SMP_MAX = acc_t'((2 ** (DATA_W - 1)) - 1);
  localparam acc_t SMP_MIN = acc_t'(-(2 ** (DATA_W - 1)));

  // sign-extend a sample into the accumulator width
  function automatic acc_t widen(input smp_t s);
    return acc_t'(s);
  endfunction

  // clip a wide value to the sample range
  function automatic smp_t clip(input acc_t v);
    if (v > SMP_MAX) return smp_t'(SMP_MAX);
    if (v < SMP_MIN) return smp_t'(SMP_MIN);
    return smp_t'(v);
  endfunction

  // weight increment: (err >>> mu) * u, rescaled by the weight fraction
  function automatic acc_t step_term(input smp_t err, input smp_t reg_u,
                                     input int mu_sh, input int frac);
    acc_t scaled_err;
    acc_t prod;
    scaled_err = widen(err) >>> mu_sh;
    prod = scaled_err * widen(reg_u);
    return prod >>> frac;
  endfunction

  // error against the saturated output
  function automatic smp_t err_of(input smp_t desired, input smp_t y);
    return clip(widen(desired) - widen(y));
  endfunction
endpackage

// File: rtl/dlms_tapline.sv
`timescale 1ns/1ps
module dlms_tapline
  import dlms_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  smp_t din,
  output smp_t taps [DEPTH]
);
  smp_t q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else if (shift_en) begin
      q[0] <= din;
      for (int i = 1; i < DEPTH; i++) q[i] <= q[i-1];
    end
  end

  assign taps = q;

  p_head_load_r5: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> q[0] == $past(din));

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
      p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(q[g]));
      if (g > 0) begin : g_mv
        p_shift_step_r5: assert property (@(posedge clk) disable iff (rst)
          shift_en |=> q[g] == $past(q[g-1]));
      end
    end
  endgenerate
endmodule

// File: rtl/dlms_dot.sv
`timescale 1ns/1ps
module dlms_dot
  import dlms_pkg::*;
#(
  parameter int TAPS  = 4,
  parameter int WFRAC = 14
) (
  input  smp_t w [TAPS],
  input  smp_t v [TAPS],
  output smp_t y
);
  acc_t prod [TAPS];
  acc_t acc_sum;

  generate
    for (genvar g = 0; g < TAPS; g++) begin : g_mul
      assign prod[g] = widen(w[g]) * widen(v[g]);
    end
  endgenerate

  always_comb begin
    acc_sum = '0;
    for (int k = 0; k < TAPS; k++) acc_sum = acc_sum + prod[k];
  end

  assign y = clip(acc_sum >>> WFRAC);
endmodule

// File: rtl/dlms_wbank.sv
`timescale 1ns/1ps
module dlms_wbank
  import dlms_pkg::*;
#(
  parameter int TAPS     = 4,
  parameter int MU_SHIFT = 4,
  parameter int WFRAC    = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic upd_en,
  input  smp_t e_old,
  input  smp_t u_old [TAPS],
  output smp_t w [TAPS]
);
  smp_t wq [TAPS];
  smp_t wn [TAPS];

  generate
    for (genvar g = 0; g < TAPS; g++) begin : g_upd
      assign wn[g] = clip(widen(wq[g]) + step_term(e_old, u_old[g], MU_SHIFT, WFRAC));

      p_frozen_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(wq[g]));
      p_zero_err_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (upd_en && e_old == '0) |=> $stable(wq[g]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) wq[i] <= '0;
    end else if (upd_en) begin
      for (int i = 0; i < TAPS; i++) wq[i] <= wn[i];
    end
  end

  assign w = wq;
endmodule

// File: rtl/dlms_filter.sv
`timescale 1ns/1ps
module dlms_filter
  import dlms_pkg::*;
#(
  parameter int TAPS      = 64,
  parameter int ADAPT_DLY = 8,
  parameter int MU_SHIFT  = 4,
  parameter int WFRAC     = 14,
  parameter bit LINE_ENH  = 1'b0,
  parameter int DECOR_DLY = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] x_in,
  input  logic signed [DATA_W-1:0] d_in,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] y_out,
  output logic signed [DATA_W-1:0] err_out
);
  localparam int HIST   = TAPS + ADAPT_DLY;
  localparam int LINE_D = HIST - 1;

  // named internal events
  smp_t u_now;
  smp_t d_now;
  smp_t y_now;
  smp_t e_now;
  smp_t adapt_err;

  smp_t dec_q   [DECOR_DLY];
  smp_t line_q  [LINE_D];
  smp_t cur_vec [HIST];
  smp_t fir_vec [TAPS];
  smp_t old_vec [TAPS];
  smp_t w_cur   [TAPS];

  // decorrelation line used in line-enhancer mode
  dlms_tapline #(.DEPTH(DECOR_DLY)) u_decor (
    .clk(clk), .rst(rst), .shift_en(in_valid), .din(x_in), .taps(dec_q)
  );

  assign u_now = LINE_ENH ? dec_q[DECOR_DLY-1] : x_in;
  assign d_now = LINE_ENH ? x_in : d_in;

  // regressor history long enough to reach the delayed vector
  dlms_tapline #(.DEPTH(LINE_D)) u_line (
    .clk(clk), .rst(rst), .shift_en(in_valid), .din(u_now), .taps(line_q)
  );

  assign cur_vec[0] = u_now;
  generate
    for (genvar g = 1; g < HIST; g++) begin : g_vec
      assign cur_vec[g] = line_q[g-1];
    end
    for (genvar g = 0; g < TAPS; g++) begin : g_sel
      assign fir_vec[g] = cur_vec[g];
      assign old_vec[g] = cur_vec[ADAPT_DLY + g];
    end
  endgenerate

  dlms_dot #(.TAPS(TAPS), .WFRAC(WFRAC)) u_dot (
    .w(w_cur), .v(fir_vec), .y(y_now)
  );

  assign e_now = err_of(d_now, y_now);

  // error history: absent for plain LMS
  generate
    if (ADAPT_DLY == 0) begin : g_nodly
      assign adapt_err = e_now;
    end else begin : g_dly
      smp_t eh_q [ADAPT_DLY];
      dlms_tapline #(.DEPTH(ADAPT_DLY)) u_ehist (
        .clk(clk), .rst(rst), .shift_en(in_valid), .din(e_now), .taps(eh_q)
      );
      assign adapt_err = eh_q[ADAPT_DLY-1];
    end
  endgenerate

  dlms_wbank #(.TAPS(TAPS), .MU_SHIFT(MU_SHIFT), .WFRAC(WFRAC)) u_wbank (
    .clk(clk), .rst(rst), .upd_en(in_valid), .e_old(adapt_err),
    .u_old(old_vec), .w(w_cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      y_out     <= '0;
      err_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        y_out   <= y_now;
        err_out <= e_now;
      end
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_outputs_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(y_out) && $stable(err_out)));
endmodule

// File: tb/tb_dlms_filter.sv
`timescale 1ns/1ps
module tb_dlms_filter;
  localparam int NI = 3;
  localparam int NT = 4;
  localparam int WF = 14;
  localparam int P_DA  [NI] = '{2, 0, 1};
  localparam int P_MU  [NI] = '{2, 2, 3};
  localparam int P_ALE [NI] = '{0, 0, 1};
  localparam int P_DEC = 1;
  localparam int NV = 22;
  // {x, d, valid}
  localparam int VEC [NV][3] = '{
    '{1000, 2000, 1}, '{-1500, 500, 1}, '{3000, -2500, 1}, '{9999, -9999, 0},
    '{2200, 1800, 1}, '{-800, -3000, 1}, '{12000, 9000, 1}, '{-7777, 4444, 0},
    '{31000, -31000, 0}, '{-9000, 4000, 1}, '{5000, 5000, 1}, '{-20000, 15000, 1},
    '{7000, -7000, 1}, '{300, 0, 1}, '{1234, 4321, 0}, '{-4000, 2000, 1},
    '{8000, 8000, 1}, '{1, -1, 1}, '{-32768, 32767, 1}, '{32767, -32768, 1},
    '{0, 0, 1}, '{-5, 5, 1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] x_in = '0;
  logic signed [15:0] d_in = '0;
  logic               ov [NI];
  logic signed [15:0] yo [NI];
  logic signed [15:0] eo [NI];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int mw  [NI][NT];
  int muh [NI][16];
  int meh [NI][16];
  int mdl [NI][4];
  int last_y [NI];
  int last_e [NI];

  always #10 clk = ~clk;

  dlms_filter #(.TAPS(NT), .ADAPT_DLY(2), .MU_SHIFT(2), .WFRAC(WF),
                .LINE_ENH(1'b0), .DECOR_DLY(1)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in), .d_in(d_in),
    .out_valid(ov[0]), .y_out(yo[0]), .err_out(eo[0]));
  dlms_filter #(.TAPS(NT), .ADAPT_DLY(0), .MU_SHIFT(2), .WFRAC(WF),
                .LINE_ENH(1'b0), .DECOR_DLY(1)) dut_lms (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in), .d_in(d_in),
    .out_valid(ov[1]), .y_out(yo[1]), .err_out(eo[1]));
  dlms_filter #(.TAPS(NT), .ADAPT_DLY(1), .MU_SHIFT(3), .WFRAC(WF),
                .LINE_ENH(1'b1), .DECOR_DLY(P_DEC)) dut_ale (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in), .d_in(d_in),
    .out_valid(ov[2]), .y_out(yo[2]), .err_out(eo[2]));

  function automatic int sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // floor division by a power of two, written without shifts
  function automatic longint fdiv(input longint a, input int sh);
    longint den = longint'(1) << sh;
    longint q = a / den;
    if (a < 0 && q * den != a) q = q - 1;
    return q;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NI; i++) begin
      for (int k = 0; k < NT; k++) mw[i][k] = 0;
      for (int k = 0; k < 16; k++) begin muh[i][k] = 0; meh[i][k] = 0; end
      for (int k = 0; k < 4; k++) mdl[i][k] = 0;
      last_y[i] = 0; last_e[i] = 0;
    end
  endtask

  task automatic model_step(input int i, input int x, input int d,
                            output int ry, output int re);
    int u, dd, eold, da;
    longint acc;
    da = P_DA[i];
    u  = (P_ALE[i] != 0) ? mdl[i][P_DEC-1] : x;
    dd = (P_ALE[i] != 0) ? x : d;
    for (int j = 3; j > 0; j--) mdl[i][j] = mdl[i][j-1];
    mdl[i][0] = x;
    for (int j = 15; j > 0; j--) muh[i][j] = muh[i][j-1];
    muh[i][0] = u;
    acc = 0;
    for (int k = 0; k < NT; k++) acc += longint'(mw[i][k]) * muh[i][k];
    ry = sat16(fdiv(acc, WF));
    re = sat16(longint'(dd) - ry);
    eold = (da == 0) ? re : meh[i][da-1];
    for (int j = 15; j > 0; j--) meh[i][j] = meh[i][j-1];
    meh[i][0] = re;
    for (int k = 0; k < NT; k++)
      mw[i][k] = sat16(mw[i][k] + fdiv(fdiv(eold, P_MU[i]) * muh[i][da+k], WF));
  endtask

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic string inst_tag(input int i, input bit is_err);
    if (i == 0) return is_err ? "R4 R5 delayed err" : "R3 R5 delayed y";
    if (i == 1) return is_err ? "R4 R6 lms err" : "R3 R6 lms y";
    return is_err ? "R8 ale err" : "R8 ale y";
  endfunction

  // drive at negedge, check at the following negedge
  task automatic apply(input int x, input int d, input bit v);
    int ry, re;
    x_in = 16'(x); d_in = 16'(d); in_valid = v;
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      check("R2 out_valid", int'(ov[i]), int'(v));
      if (v) begin
        model_step(i, x, d, ry, re);
        last_y[i] = ry; last_e[i] = re;
        check(inst_tag(i, 1'b0), int'(yo[i]), ry);
        check(inst_tag(i, 1'b1), int'(eo[i]), re);
      end else begin
        check("R9 idle y hold", int'(yo[i]), last_y[i]);
        check("R9 idle err hold", int'(eo[i]), last_e[i]);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    rst = 1'b1; in_valid = 1'b1; x_in = 16'sd1234; d_in = 16'sd99;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      check("R1 reset out_valid", int'(ov[i]), 0);
      check("R1 reset y", int'(yo[i]), 0);
      check("R1 reset err", int'(eo[i]), 0);
    end
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    // table walk
    for (int r = 0; r < NV; r++) apply(VEC[r][0], VEC[r][1], VEC[r][2] != 0);

    // full-scale run to push weights into saturation (R7)
    for (int r = 0; r < 10; r++) apply(32767, -32768, 1'b1);
    for (int r = 0; r < 6; r++) apply(-32768, 32767, 1'b1);
    for (int r = 0; r < 4; r++) apply((r % 2 == 0) ? 20000 : -20000, 0, 1'b1);
    for (int i = 0; i < NI; i++) check("R7 saturated y", int'(yo[i]), last_y[i]);

    // mid-run reset (R10)
    rst = 1'b1; in_valid = 1'b1; x_in = 16'sd7000; d_in = -16'sd7000;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      check("R10 reset y", int'(yo[i]), 0);
      check("R10 reset err", int'(eo[i]), 0);
      check("R10 reset out_valid", int'(ov[i]), 0);
    end
    rst = 1'b0; in_valid = 1'b0;
    model_reset();
    @(negedge clk);
    for (int r = 0; r < 8; r++) apply(VEC[r][0], VEC[r][1], VEC[r][2] != 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule